// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block gathers up to eight peripheral interrupt requests into a pending register. It combines them into one level output for a higher-level interrupt controller. Peripherals post requests through a set strobe and retire them through a clear strobe, and each strobe carries a vector of request bits. Software writes a byte-wide enable mask through a small register port. A request takes part in the combined output only where its mask bit is 1. The register port also holds a secondary mask byte, which is stored and can be read but does not affect the output.

The output follows a two-state controller with states `ST_QUIET` (output low) and `ST_RAISED` (output high). There are two transitions:

- **raise** (`ST_QUIET` to `ST_RAISED`) is taken when a set strobe or a primary mask write leaves a non-zero enabled set.
- **release** (`ST_RAISED` to `ST_QUIET`) is taken only when a clear strobe leaves the enabled set empty.

In every other case the controller keeps its state. The release rule means that masking off every pending request does not drop the output. Only a clear operation does.

Enabled set means pending AND primary mask. All state is registered, so every effect appears one clock after the strobe or write that causes it.

Top module: `irqagg_top`

## Requirements
- R1: A set strobe (`set_vld`=1) ORs `set_vec` into the pending register; the result is visible on `pending_q` one cycle later.
- R2: A clear strobe (`clr_vld`=1) replaces the pending register with pending AND NOT `clr_vec`, visible one cycle later.
- R3: When set and clear strobes arrive in the same cycle, the set is applied first and the clear second, so a bit present in both vectors ends up 0.
- R4: When the output is low and a set strobe or a primary mask write (`wr_en`=1, `wr_sel`=0) leaves pending AND mask non-zero, `irq_out` goes high one cycle later.
- R5: A primary mask write replaces all eight mask bits with `wr_data`, visible on `mask_q` one cycle later.
- R6: A primary mask write that disables every pending bit leaves `irq_out` high.
- R7: `irq_out` falls one cycle after a clear strobe that leaves pending AND mask zero. While any enabled bit remains pending, or when there is no clear strobe, it stays high.
- R8: A write with `wr_sel`=1 stores `wr_data` in the secondary mask (`shadow_q`) and has no effect on `irq_out` or on the pending register.
- R9: After reset the pending register, both masks and `irq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_vld | input | 1 | Set strobe |
| set_vec | input | 8 | Request bits to post |
| clr_vld | input | 1 | Clear strobe |
| clr_vec | input | 8 | Request bits to retire |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 1 | Register select: 0 primary mask, 1 secondary mask |
| wr_data | input | 8 | Register write data |
| irq_out | output | 1 | Combined interrupt level |
| pending_q | output | 8 | Pending register read-back |
| mask_q | output | 8 | Primary mask read-back |
| shadow_q | output | 8 | Secondary mask read-back |

## Verification
The bench raises the output and then writes a mask that disables every pending bit. A design that released on the mask path would drop `irq_out` there. It then issues a clear of an unrelated bit, where a design that released only on an empty pending register, ignoring the mask, would hold the line high forever. Requests posted while masked are followed by a mask write that enables them, which catches a controller that raises only on set strobes. Same-cycle set and clear of the same bit catches a reversed update order. Secondary-mask writes are checked to leave the output unchanged.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } agg_state_e;
endpackage

// File: rtl/irqagg_regs.sv
module irqagg_regs #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_vld,
    input  logic [N-1:0] set_vec,
    input  logic         clr_vld,
    input  logic [N-1:0] clr_vec,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [N-1:0] wr_data,
    output logic [N-1:0] enabled_nxt,
    output logic         trigger,
    output logic [N-1:0] pending_q,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] shadow_q
);
    logic [N-1:0] after_set;
    logic [N-1:0] pending_nxt;
    logic [N-1:0] mask_nxt;
    logic         wr_primary;

    assign wr_primary = wr_en && !wr_sel;

    always_comb begin
        // set first, clear second
        after_set   = set_vld ? (pending_q | set_vec) : pending_q;
        pending_nxt = clr_vld ? (after_set & ~clr_vec) : after_set;
        mask_nxt    = wr_primary ? wr_data : mask_q;
        enabled_nxt = pending_nxt & mask_nxt;
        trigger     = set_vld || wr_primary;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            mask_q    <= '0;
            shadow_q  <= '0;
        end else begin
            pending_q <= pending_nxt;
            mask_q    <= mask_nxt;
            if (wr_en && wr_sel) begin
                shadow_q <= wr_data;
            end
        end
    end
endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trigger,
    input  logic         clr_vld,
    input  logic [N-1:0] enabled_nxt,
    output logic         irq_out
);
    import irqagg_pkg::*;

    agg_state_e state_q;
    agg_state_e state_d;
    logic       any_enabled;

    assign any_enabled = |enabled_nxt;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (trigger && any_enabled) begin
                    state_d = ST_RAISED;   // raise
                end
            end
            ST_RAISED: begin
                if (clr_vld && !any_enabled) begin
                    state_d = ST_QUIET;    // release
                end
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_out = (state_q == ST_RAISED);
    end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_vld,
    input  logic [N-1:0] set_vec,
    input  logic         clr_vld,
    input  logic [N-1:0] clr_vec,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [N-1:0] wr_data,
    output logic         irq_out,
    output logic [N-1:0] pending_q,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] shadow_q
);
    logic [N-1:0] enabled_nxt;
    logic         trigger;

    irqagg_regs #(.N(N)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_vld     (set_vld),
        .set_vec     (set_vec),
        .clr_vld     (clr_vld),
        .clr_vec     (clr_vec),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .enabled_nxt (enabled_nxt),
        .trigger     (trigger),
        .pending_q   (pending_q),
        .mask_q      (mask_q),
        .shadow_q    (shadow_q)
    );

    irqagg_ctrl #(.N(N)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .trigger     (trigger),
        .clr_vld     (clr_vld),
        .enabled_nxt (enabled_nxt),
        .irq_out     (irq_out)
    );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         set_vld,
    input logic [N-1:0] set_vec,
    input logic         clr_vld,
    input logic [N-1:0] clr_vec,
    input logic         wr_en,
    input logic         wr_sel,
    input logic         irq_out,
    input logic [N-1:0] pending_q,
    input logic [N-1:0] mask_q
);
    AST_SET_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld && !clr_vld) |=> ((pending_q & $past(set_vec)) == $past(set_vec))); // R1

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vld |=> ((pending_q & $past(clr_vec)) == '0)); // R3

    AST_QUIET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> ((pending_q & mask_q) == '0)); // R7

    AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !clr_vld) |=> irq_out); // R6

    AST_RAISE_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && set_vld && !clr_vld && !wr_en && ((set_vec & mask_q) != '0)) |=> irq_out); // R4

    AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !set_vld && !clr_vld) |=> ($stable(irq_out) && $stable(pending_q))); // R8
endmodule

bind irqagg_top irqagg_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vld   (set_vld),
    .set_vec   (set_vec),
    .clr_vld   (clr_vld),
    .clr_vec   (clr_vec),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .irq_out   (irq_out),
    .pending_q (pending_q),
    .mask_q    (mask_q)
);

// File: tb/test_irqagg_top.sv
module test_irqagg_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         set_vld = 1'b0;
    logic [N-1:0] set_vec = '0;
    logic         clr_vld = 1'b0;
    logic [N-1:0] clr_vec = '0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic         irq_out;
    logic [N-1:0] pending_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] shadow_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] m_pend = '0;
    logic [N-1:0] m_mask = '0;
    logic [N-1:0] m_shadow = '0;
    logic         m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqagg_top #(.N(N)) i_irqagg_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vld   (set_vld),
        .set_vec   (set_vec),
        .clr_vld   (clr_vld),
        .clr_vec   (clr_vec),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .irq_out   (irq_out),
        .pending_q (pending_q),
        .mask_q    (mask_q),
        .shadow_q  (shadow_q)
    );

    function automatic logic [N-1:0] next_pend(logic [N-1:0] p, logic sv, logic [N-1:0] sb,
                                               logic cv, logic [N-1:0] cb);
        logic [N-1:0] t;
        t = sv ? (p | sb) : p;
        return cv ? (t & ~cb) : t;
    endfunction

    function automatic logic next_irq(logic irq, logic trig, logic cv, logic [N-1:0] en);
        if (!irq && trig && (en != '0)) return 1'b1;
        if (irq && cv && (en == '0)) return 1'b0;
        return irq;
    endfunction

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(string ptag, string itag);
        check(ptag, pending_q, m_pend);
        check("R5 mask", mask_q, m_mask);
        check("R8 shadow", shadow_q, m_shadow);
        check(itag, {{(N-1){1'b0}}, irq_out}, {{(N-1){1'b0}}, m_irq});
    endtask

    // drive at a falling edge, model the next rising edge, compare at the next falling edge
    task automatic step(logic sv, logic [N-1:0] sb, logic cv, logic [N-1:0] cb,
                        logic we, logic ws, logic [N-1:0] wd);
        logic [N-1:0] pn;
        logic [N-1:0] mn;
        string ptag;
        string itag;
        set_vld = sv; set_vec = sb; clr_vld = cv; clr_vec = cb;
        wr_en = we; wr_sel = ws; wr_data = wd;
        pn = next_pend(m_pend, sv, sb, cv, cb);
        mn = (we && !ws) ? wd : m_mask;
        if (sv && cv) ptag = "R3 set-then-clear";
        else if (cv) ptag = "R2 clear";
        else ptag = "R1 set";
        if (!m_irq) itag = "R4 raise";
        else if (cv) itag = "R7 release";
        else if (we && ws) itag = "R8 no effect";
        else itag = "R6 hold";
        m_irq = next_irq(m_irq, sv || (we && !ws), cv, pn & mn);
        m_pend = pn;
        m_mask = mn;
        if (we && ws) m_shadow = wd;
        @(negedge clk);
        compare_all(ptag, itag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd24681);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R9 reset", "R9 reset");

        // masked request, then a mask write enables it: R4 via mask path
        step(1, 8'h04, 0, 8'h00, 0, 0, 8'h00);
        step(0, 8'h00, 0, 8'h00, 1, 0, 8'h0C);
        // mask write disabling all pending bits keeps output high: R6
        step(0, 8'h00, 0, 8'h00, 1, 0, 8'h00);
        step(0, 8'h00, 0, 8'h00, 0, 0, 8'h00);
        // clear of an unrelated bit with enabled set empty releases: R7
        step(0, 8'h00, 1, 8'h80, 0, 0, 8'h00);
        // pending still holds bit 2; re-enable, raise, partial clear keeps high
        step(1, 8'h01, 0, 8'h00, 1, 0, 8'h05);
        step(0, 8'h00, 1, 8'h01, 0, 0, 8'h00);
        step(0, 8'h00, 1, 8'h04, 0, 0, 8'h00);
        // same-cycle set and clear of one bit: R3
        step(1, 8'h10, 1, 8'h10, 0, 0, 8'h00);
        // secondary mask write: R8
        step(0, 8'h00, 0, 8'h00, 1, 1, 8'hFF);
        step(1, 8'h20, 0, 8'h00, 0, 0, 8'h00);
        step(0, 8'h00, 0, 8'h00, 1, 1, 8'h00);

        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 2) == 0, N'($urandom & $urandom),
                 $urandom_range(0, 2) == 0, N'($urandom | $urandom),
                 $urandom_range(0, 4) == 0, $urandom_range(0, 1) == 1,
                 N'($urandom & $urandom));
        end
        step(0, 8'h00, 1, 8'hFF, 0, 0, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule